// File: doc/BRIEF.md
# Clock Multiplier Control and Fractional Scaler

This block is a register-level digital model of a clock multiplier's control. It works in the domain of the already multiplied fast clock. A byte-wide control register, reached through write and read strobes, holds an enable, a self-clearing lock-start strobe, a read-only ready flag, a three-bit scaling code and a two-bit source code. The source code is driven out as the selection for the system clock multiplexer.

The scaler turns the fast clock into a clock-enable pattern that downstream logic uses as its effective clock. Some codes pass two of every N fast cycles, where N runs from 3 to 7. The others pass every cycle, and the doubling source modes always pass every cycle. An accepted lock-start runs a counter of parameterized length before ready is raised. The enable output stays low until ready is 1, so no clock reaches downstream logic before the multiplier has settled.

Top module: `clkmul_ctrl`

## Requirements
- R1: After synchronous reset, read data is 0x00, ready is 0, the clock enable is 0 and the source selection is 00.
- R2: The register byte is enable at bit 7, start at bit 6, ready at bit 5, scaling code at bits 4:2 and source code at bits 1:0. A read returns the enable, the code and the source as last written, with bit 6 always 0 and bit 5 equal to ready. A write to bit 5 has no effect. Read data is updated one cycle after the read strobe.
- R3: A write with bit 6 set is accepted only when the enable is already 1 and the same write keeps bit 7 at 1. Otherwise it starts no lock, and ready stays 0.
- R4: After an accepted start written at clock edge E0, ready reads 0 through edge E(LOCK_CYCLES-1) and reads 1 after edge E(LOCK_CYCLES).
- R5: A write with bit 7 at 0 clears ready at that same edge and aborts a lock in progress. A later re-enable without a new start leaves ready at 0.
- R6: Whenever ready was 0 in the previous cycle, the clock enable is 0.
- R7: With source code 10 or 11 and scaling code 000, 001 or 010, the clock enable is 1 in every cycle while ready.
- R8: With source code 10 or 11 and a scaling code c from 3 to 7, the clock enable is 1 in exactly 2 of every c consecutive cycles while ready.
- R9: With source code 00 or 01, the scaling code is ignored and the clock enable is 1 in every cycle while ready.
- R10: The source selection output equals the last written source code from the edge of the write onward.
- R11: A write that changes the scaling code restarts the pattern. With a write at edge E0 and c from 3 to 7, the enable sampled after edges E1 to Ec is 1 exactly at positions 0 and floor(c/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from the multiplier |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ready | output | 1 | Lock complete flag |
| clk_en | output | 1 | Scaled clock-enable pattern |
| src_sel | output | 2 | System clock source selection |

## Verification
The bench builds the block with LOCK_CYCLES set to 37. This value is short enough to sweep the lock window edge by edge, and it still leaves room for an abort in the middle of a lock. All eight scaling codes are tried against all four source codes. Each pulse count is taken over 420 cycles, which is a common multiple of every divisor, so an exact count is expected whatever the starting phase. Random configurations add windows that are random multiples of the effective divisor.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
  localparam int BIT_EN    = 7;
  localparam int BIT_START = 6;

  typedef struct packed {
    logic       en;
    logic [2:0] code;
    logic [1:0] src;
  } ctrl_t;

  // effective divisor: 1 for codes 0..2, else the code itself
  function automatic logic [2:0] eff_div(input logic [2:0] code);
    return (code <= 3'd2) ? 3'd1 : code;
  endfunction
endpackage

// File: rtl/clkmul_regs.sv
module clkmul_regs
  import clkmul_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic        rd,
  input  logic [7:0]  wdata,
  input  logic        ready,
  output ctrl_t       ctrl,
  output logic        start,
  output logic        abort,
  output logic [7:0]  rdata
);
  // lock start needs enable held before and during the write
  assign start = wr & wdata[BIT_START] & wdata[BIT_EN] & ctrl.en;
  assign abort = wr & ~wdata[BIT_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      rdata <= '0;
    end else begin
      if (wr) ctrl <= '{en: wdata[7], code: wdata[4:2], src: wdata[1:0]};
      if (rd) rdata <= {ctrl.en, 1'b0, ready, ctrl.code, ctrl.src};
    end
  end
endmodule

// File: rtl/clkmul_lock.sv
module clkmul_lock #(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic ready
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy  <= 1'b0;
      cnt   <= '0;
      ready <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= '0;
      ready <= 1'b0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy  <= 1'b0;
        cnt   <= '0;
        ready <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkmul_scaler.sv
module clkmul_scaler
  import clkmul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ready,
  input  logic [2:0] code,
  input  logic [1:0] src,
  output logic       clk_en
);
  logic [2:0] cnt, last_code, cnt_now, n_div, half;
  logic       bypass, restart;

  always_comb begin
    n_div   = eff_div(code);
    half    = n_div >> 1;
    bypass  = ~src[1] | (n_div == 3'd1);
    restart = (code != last_code);
    cnt_now = restart ? 3'd0 : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      last_code <= '0;
      clk_en    <= 1'b0;
    end else begin
      last_code <= code;
      cnt       <= (cnt_now == n_div - 3'd1) ? 3'd0 : cnt_now + 3'd1;
      clk_en    <= ready & (bypass | (cnt_now == 3'd0) | (cnt_now == half));
    end
  end
endmodule

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl
  import clkmul_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       ready,
  output logic       clk_en,
  output logic [1:0] src_sel
);
  ctrl_t ctrl_q;
  logic  start, abort;

  clkmul_regs u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .ready(ready), .ctrl(ctrl_q), .start(start), .abort(abort), .rdata(reg_rdata)
  );

  clkmul_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .ready(ready)
  );

  clkmul_scaler u_scaler (
    .clk(clk), .rst(rst), .ready(ready), .code(ctrl_q.code),
    .src(ctrl_q.src), .clk_en(clk_en)
  );

  assign src_sel = ctrl_q.src;
endmodule

// File: rtl/clkmul_ctrl_chk.sv
module clkmul_ctrl_chk #(
  parameter int LOCK_CYCLES = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       ready,
  input logic       clk_en,
  input logic [1:0] src_sel,
  input logic       en_q
);
  localparam int WW = $clog2(LOCK_CYCLES + 3);
  localparam logic [WW-1:0] SAT = WW'(LOCK_CYCLES + 2);
  localparam logic [WW-1:0] HIT = WW'(LOCK_CYCLES + 1);

  logic          accept, drop;
  logic [WW-1:0] win;

  assign accept = reg_wr & reg_wdata[6] & reg_wdata[7] & en_q;
  assign drop   = reg_wr & ~reg_wdata[7];

  always_ff @(posedge clk) begin
    if (rst || drop)                win <= '0;
    else if (accept)                win <= WW'(1);
    else if (win != 0 && win != SAT) win <= win + 1'b1;
  end

  // R4
  lock_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> win == HIT);

  // R5
  drop_ready_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> !ready);

  // R6
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !clk_en);

  // R9
  bypass_every_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !src_sel[1] && !reg_wr) |=> clk_en);

  // R2
  read_ready_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> (reg_rdata[5] == $past(ready)) && !reg_rdata[6]);

  // R10
  src_follow_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> src_sel == $past(reg_wdata[1:0]));
endmodule

bind clkmul_ctrl clkmul_ctrl_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ready(ready),
  .clk_en(clk_en), .src_sel(src_sel), .en_q(ctrl_q.en)
);

// File: tb/clkmul_ctrl_test.sv
module clkmul_ctrl_test;
  localparam int L = 37;
  localparam int WIN = 420;

  logic       clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       ready, clk_en;
  logic [1:0] src_sel;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  clkmul_ctrl #(.LOCK_CYCLES(L)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ready(ready),
    .clk_en(clk_en), .src_sel(src_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (clk_en) c++; end
  endtask

  function automatic int div_of(input logic [1:0] s, input logic [2:0] c);
    return (!s[1] || c <= 3'd2) ? 1 : int'(c);
  endfunction

  function automatic int exp_pulses(input logic [1:0] s, input logic [2:0] c, input int n);
    return (div_of(s, c) == 1) ? n : 2 * n / div_of(s, c);
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int c, ok_seq;
    void'($urandom(32'd20240));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(ready == 0 && clk_en == 0 && src_sel == 0, "R1 outputs", {ready, clk_en, src_sel}, 0);
    do_rd(rd);
    chk(rd == 8'h00, "R1 readback", rd, 0);

    // R3: start with enable low is ignored
    do_wr(8'h4B);
    repeat (L + 5) @(negedge clk);
    chk(ready == 0, "R3 start while disabled", ready, 0);
    // R3: enable and start in one write, enable was low before
    do_wr(8'hFF);
    repeat (L + 5) @(negedge clk);
    chk(ready == 0, "R3 start with enable in same write", ready, 0);

    // R2: bit6 reads 0, bit5 write ignored
    do_rd(rd);
    chk(rd == 8'h9F, "R2 readback fields", rd, 8'h9F);
    // R10
    chk(src_sel == 2'b11, "R10 source", src_sel, 3);

    // R6: enabled but not ready
    count_en(50, c);
    chk(c == 0, "R6 gated before lock", c, 0);

    // R4: lock window
    do_wr(8'hDF);
    ok_seq = 1;
    for (int i = 1; i < L; i++) begin @(negedge clk); if (ready) ok_seq = 0; end
    chk(ok_seq == 1, "R4 ready early", ok_seq, 1);
    @(negedge clk);
    chk(ready == 1, "R4 ready at count", ready, 1);
    do_rd(rd);
    chk(rd == 8'hBF, "R2 ready bit readback", rd, 8'hBF);

    // R11: pattern restart on code change, code 6
    do_wr(8'h9A);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(clk_en == (i == 0 || i == 3), "R11 restart code 6", clk_en, (i == 0 || i == 3));
    end
    // R11: code 5
    do_wr(8'h96);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(clk_en == (i == 0 || i == 2), "R11 restart code 5", clk_en, (i == 0 || i == 2));
    end

    // R7 R8 R9 R10: full sweep
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 8; d++) begin
        do_wr(8'h80 | 8'(d << 2) | 8'(s));
        repeat (3) @(negedge clk);
        chk(src_sel == 2'(s), "R10 sweep source", src_sel, s);
        count_en(WIN, c);
        if (s < 2)
          chk(c == exp_pulses(2'(s), 3'(d), WIN), "R9 bypass", c, exp_pulses(2'(s), 3'(d), WIN));
        else if (d <= 2)
          chk(c == exp_pulses(2'(s), 3'(d), WIN), "R7 unity", c, exp_pulses(2'(s), 3'(d), WIN));
        else
          chk(c == exp_pulses(2'(s), 3'(d), WIN), "R8 ratio", c, exp_pulses(2'(s), 3'(d), WIN));
      end
    end

    // R8 R9: random configurations and window lengths
    for (int k = 0; k < 30; k++) begin
      logic [1:0] s;
      logic [2:0] d;
      int n;
      s = 2'($urandom);
      d = 3'($urandom);
      do_wr(8'h80 | {3'b0, d, s});
      repeat (2 + $urandom % 5) @(negedge clk);
      n = div_of(s, d) * (1 + $urandom % 40);
      count_en(n, c);
      chk(c == exp_pulses(s, d, n), "R8 random window", c, exp_pulses(s, d, n));
    end

    // R5: drop enable clears ready immediately
    do_wr(8'h1E);
    chk(ready == 0, "R5 drop clears ready", ready, 0);
    @(negedge clk);
    chk(clk_en == 0, "R6 gated after drop", clk_en, 0);
    // R5: abort a lock in progress
    do_wr(8'h9E);
    do_wr(8'hDE);
    repeat (10) @(negedge clk);
    do_wr(8'h1E);
    do_wr(8'h9E);
    repeat (L + 5) @(negedge clk);
    chk(ready == 0, "R5 aborted lock stays unready", ready, 0);
    // R4: fresh start after abort still locks
    do_wr(8'hDE);
    repeat (L) @(negedge clk);
    chk(ready == 1, "R4 relock", ready, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule